// File: doc/BRIEF.md
# Byte-Stream Packet Port

This block is a memory-mapped slave that carries whole packets between a host processor and a network-facing byte stream. The host never sees a bus-wide data path. It moves payload one byte per register access, through a receive data port and a transmit data port. A count register beside each port tracks the bytes that are still outstanding. On the network side the block has a byte-wide receive input and a byte-wide transmit output, each framed by a valid strobe and a last-byte marker.

When a packet arrives, the block stores it and publishes its length. It then raises a receive-done flag and refuses further traffic until the host has drained the bytes and cleared the flag. To transmit, the host programs a length and then pushes that many bytes. The packet leaves on the network output only once the final byte is in, and a transmit-done flag follows. A self-test bit lets software raise the interrupt line on demand. The interrupt is the OR of the two done flags and the pending test request.

Top module: `pktport`

## Requirements
- R1: After reset the interrupt line, the transmit valid and every status, flag and count register read as 0.
- R2: The 64-bit identification value (low word at 0x00, high word at 0x04) and the routing word at 0x20 read back their parameter values. Host writes to any read-only register (identification, routing, busy at 0x0C) have no effect.
- R3: When a packet ends on the receive input (valid with last), the receive count at 0x14 holds its length in bytes and bit 1 of the interrupt control word at 0x08 is set.
- R4: Each read of the receive data port at 0x10 returns the next stored byte in arrival order in bits 7:0, with bits 31:8 zero, and lowers the receive count by one. A read when the count is 0 returns 0 and leaves the count at 0.
- R5: A packet is accepted only if the receive count is 0 and bit 1 is clear when its first byte arrives. Otherwise all of its bytes, up to and including the one marked last, are dropped, even when the lock is lifted part-way through the packet.
- R6: The busy word at 0x0C reads 1 while a receive packet is being filled or a transmit packet is being sent, and 0 otherwise.
- R7: After the host writes a length N to the transmit count at 0x1C and N bytes to the transmit data port at 0x18, the block drives N consecutive valid beats carrying those bytes in order. Last is asserted only on the final beat, and no beat appears before the N-th byte is written.
- R8: After the final transmit beat, bit 0 of the interrupt control word is set and the transmit count reads 0.
- R9: A transmit length above 65536 is stored as 65536. A length of 0 starts no transfer.
- R10: Writing 1 to bit 0 or bit 1 of the interrupt control word clears that flag. A 0 in that bit position leaves it unchanged.
- R11: Writing a word with bit 31 set to the interrupt control register raises the interrupt. The next read shows bit 31 as 1, and later reads show 0. The interrupt stays asserted until the host writes the value 0 to that register.
- R12: The interrupt output is high exactly when transmit done, receive done or the test request is pending.
- R13: Only bits 7:0 of a transmit data write are sent. Data writes beyond the programmed length, or with no length programmed, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Receive byte ends the packet |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Transmit byte ends the packet |
| irq | output | 1 | Interrupt request |

## Verification
A wrong write or read pointer shows up on the first data-port read or transmit beat as a misordered or stale byte. A broken lock lets a second packet overwrite the first, and the next count read shows a jump instead of a step of one. A stuck transmit state shows as valid beats starting before the final data write, or a done flag that never appears, within a few cycles of the last byte. A mis-held test request is visible on the interrupt pin on the cycle after the clearing write.

// File: rtl/pktport_pkg.sv
package pktport_pkg;
    localparam int BUS_AW = 6;

    localparam logic [BUS_AW-1:0] OFS_ID_LO  = 6'h00;
    localparam logic [BUS_AW-1:0] OFS_ID_HI  = 6'h04;
    localparam logic [BUS_AW-1:0] OFS_CTL    = 6'h08;
    localparam logic [BUS_AW-1:0] OFS_BUSY   = 6'h0C;
    localparam logic [BUS_AW-1:0] OFS_RXDATA = 6'h10;
    localparam logic [BUS_AW-1:0] OFS_RXCNT  = 6'h14;
    localparam logic [BUS_AW-1:0] OFS_TXDATA = 6'h18;
    localparam logic [BUS_AW-1:0] OFS_TXCNT  = 6'h1C;
    localparam logic [BUS_AW-1:0] OFS_ROUTE  = 6'h20;

    localparam int CTL_TX_BIT   = 0;
    localparam int CTL_RX_BIT   = 1;
    localparam int CTL_TEST_BIT = 31;

    typedef enum logic [1:0] {RX_IDLE, RX_FILL, RX_SKIP} rx_state_e;
    typedef enum logic       {TX_LOAD, TX_SEND}          tx_state_e;
endpackage

// File: rtl/pktport_buf.sv
module pktport_buf #(
    parameter int DEPTH = 1024,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/pktport_rx.sv
module pktport_rx
    import pktport_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int CNT_W = 17,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    input  logic             pop,
    input  logic             clr_done,
    output logic             done,
    output logic [CNT_W-1:0] count,
    output logic [7:0]       head,
    output logic             filling
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

    typedef struct packed {
        rx_state_e        st;
        logic [CNT_W-1:0] wptr;
        logic [AW-1:0]    rptr;
        logic [CNT_W-1:0] count;
        logic             done;
    } rx_regs_t;

    rx_regs_t q, d;
    logic          wr_en;
    logic [AW-1:0] waddr;
    logic          locked;

    always_comb begin
        d      = q;
        wr_en  = 1'b0;
        waddr  = q.wptr[AW-1:0];
        locked = q.done || (q.count != '0);

        if (pop && q.count != '0) begin
            d.count = q.count - ONE_C;
            d.rptr  = q.rptr + 1'b1;
        end
        if (clr_done) d.done = 1'b0;

        unique case (q.st)
            RX_IDLE: begin
                if (in_valid) begin
                    if (locked) begin
                        if (!in_last) d.st = RX_SKIP;
                    end else begin
                        wr_en = 1'b1;
                        waddr = '0;
                        if (in_last) begin
                            d.count = ONE_C;
                            d.done  = 1'b1;
                            d.rptr  = '0;
                        end else begin
                            d.st   = RX_FILL;
                            d.wptr = ONE_C;
                        end
                    end
                end
            end
            RX_FILL: begin
                if (in_valid) begin
                    wr_en = (q.wptr < DEPTH_C);
                    if (q.wptr != '1) d.wptr = q.wptr + ONE_C;
                    if (in_last) begin
                        d.count = (q.wptr < DEPTH_C) ? q.wptr + ONE_C : DEPTH_C;
                        d.done  = 1'b1;
                        d.rptr  = '0;
                        d.st    = RX_IDLE;
                    end
                end
            end
            RX_SKIP: begin
                if (in_valid && in_last) d.st = RX_IDLE;
            end
            default: d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: RX_IDLE, wptr: '0, rptr: '0, count: '0, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    pktport_buf #(.DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .we    (wr_en),
        .waddr (waddr),
        .wdata (in_data),
        .raddr (q.rptr),
        .rdata (head)
    );

    assign done    = q.done;
    assign count   = q.count;
    assign filling = (q.st == RX_FILL);
endmodule

// File: rtl/pktport_tx.sv
module pktport_tx
    import pktport_pkg::*;
#(
    parameter int DEPTH   = 1024,
    parameter int MAX_LEN = 65536,
    parameter int CNT_W   = 17,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             len_wr,
    input  logic [31:0]      len_val,
    input  logic             data_wr,
    input  logic [7:0]       data_byte,
    input  logic             clr_done,
    output logic             done,
    output logic [CNT_W-1:0] count,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_last,
    output logic             sending
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] MAX_C   = CNT_W'(MAX_LEN);
    localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

    typedef struct packed {
        tx_state_e        st;
        logic [CNT_W-1:0] len;
        logic [CNT_W-1:0] wcnt;
        logic [CNT_W-1:0] rptr;
        logic             done;
    } tx_regs_t;

    tx_regs_t q, d;
    logic     wr_en;
    logic     at_end;

    always_comb begin
        d      = q;
        wr_en  = 1'b0;
        at_end = (q.rptr == q.len - ONE_C);

        if (clr_done) d.done = 1'b0;

        unique case (q.st)
            TX_LOAD: begin
                if (len_wr) begin
                    d.len  = (len_val > 32'(MAX_LEN)) ? MAX_C : len_val[CNT_W-1:0];
                    d.wcnt = '0;
                end else if (data_wr && q.wcnt < q.len) begin
                    wr_en  = (q.wcnt < DEPTH_C);
                    d.wcnt = q.wcnt + ONE_C;
                    if (q.wcnt + ONE_C == q.len) begin
                        d.st   = TX_SEND;
                        d.rptr = '0;
                    end
                end
            end
            TX_SEND: begin
                d.rptr = q.rptr + ONE_C;
                if (at_end) begin
                    d.st   = TX_LOAD;
                    d.done = 1'b1;
                    d.len  = '0;
                    d.wcnt = '0;
                end
            end
            default: d.st = TX_LOAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: TX_LOAD, len: '0, wcnt: '0, rptr: '0, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    pktport_buf #(.DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .we    (wr_en),
        .waddr (q.wcnt[AW-1:0]),
        .wdata (data_byte),
        .raddr (q.rptr[AW-1:0]),
        .rdata (out_data)
    );

    assign done      = q.done;
    assign count     = q.len;
    assign out_valid = (q.st == TX_SEND);
    assign out_last  = (q.st == TX_SEND) && at_end;
    assign sending   = (q.st == TX_SEND);
endmodule

// File: rtl/pktport.sv
module pktport
    import pktport_pkg::*;
#(
    parameter int          DEPTH       = 1024,
    parameter int          MAX_LEN     = 65536,
    parameter logic [63:0] ID_VALUE    = 64'h5042_5354_0000_0102,
    parameter logic [31:0] ROUTE_VALUE = 32'h0000_0002,
    localparam int CNT_W = $clog2(MAX_LEN) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    output logic              irq
);
    typedef struct packed {
        logic [31:0] rdata;
        logic        test_seen;
        logic        test_line;
    } top_regs_t;

    top_regs_t st_q, st_d;

    logic             rx_done, tx_done, rx_filling, tx_sending, busy, test_line;
    logic [CNT_W-1:0] rx_cnt, tx_cnt;
    logic [7:0]       rx_head;
    logic             wr_ctl, rd_ctl, rx_pop, clr_tx, clr_rx;

    assign wr_ctl = bus_wr && (bus_addr == OFS_CTL);
    assign rd_ctl = bus_rd && (bus_addr == OFS_CTL);
    assign rx_pop = bus_rd && (bus_addr == OFS_RXDATA);
    assign clr_tx = wr_ctl && bus_wdata[CTL_TX_BIT];
    assign clr_rx = wr_ctl && bus_wdata[CTL_RX_BIT];
    assign busy   = rx_filling || tx_sending;

    pktport_rx #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (rx_valid),
        .in_data  (rx_data),
        .in_last  (rx_last),
        .pop      (rx_pop),
        .clr_done (clr_rx),
        .done     (rx_done),
        .count    (rx_cnt),
        .head     (rx_head),
        .filling  (rx_filling)
    );

    pktport_tx #(.DEPTH(DEPTH), .MAX_LEN(MAX_LEN), .CNT_W(CNT_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .len_wr    (bus_wr && bus_addr == OFS_TXCNT),
        .len_val   (bus_wdata),
        .data_wr   (bus_wr && bus_addr == OFS_TXDATA),
        .data_byte (bus_wdata[7:0]),
        .clr_done  (clr_tx),
        .done      (tx_done),
        .count     (tx_cnt),
        .out_valid (tx_valid),
        .out_data  (tx_data),
        .out_last  (tx_last),
        .sending   (tx_sending)
    );

    always_comb begin
        st_d = st_q;

        if (rd_ctl) st_d.test_seen = 1'b0;
        if (wr_ctl) begin
            if (bus_wdata[CTL_TEST_BIT]) begin
                st_d.test_seen = 1'b1;
                st_d.test_line = 1'b1;
            end else if (bus_wdata == 32'd0) begin
                st_d.test_line = 1'b0;
            end
        end

        if (bus_rd) begin
            unique case (bus_addr)
                OFS_ID_LO:  st_d.rdata = ID_VALUE[31:0];
                OFS_ID_HI:  st_d.rdata = ID_VALUE[63:32];
                OFS_CTL:    st_d.rdata = {st_q.test_seen, 29'd0, rx_done, tx_done};
                OFS_BUSY:   st_d.rdata = {31'd0, busy};
                OFS_RXDATA: st_d.rdata = (rx_cnt != '0) ? {24'd0, rx_head} : 32'd0;
                OFS_RXCNT:  st_d.rdata = 32'(rx_cnt);
                OFS_TXCNT:  st_d.rdata = 32'(tx_cnt);
                OFS_ROUTE:  st_d.rdata = ROUTE_VALUE;
                default:    st_d.rdata = 32'd0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{rdata: 32'd0, test_seen: 1'b0, test_line: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign test_line = st_q.test_line;
    assign bus_rdata = st_q.rdata;
    assign irq       = tx_done || rx_done || test_line;
endmodule

// File: rtl/pktport_chk.sv
module pktport_chk
    import pktport_pkg::*;
#(
    parameter int CNT_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [BUS_AW-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              tx_valid,
    input logic              tx_last,
    input logic              irq,
    input logic              busy,
    input logic              rx_done,
    input logic [CNT_W-1:0]  rx_cnt,
    input logic              test_line
);
    // R6: a beat on the transmit output implies the busy word reads 1
    a_r6_busy_on_send: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> busy);

    // R7: the last marker only accompanies a valid beat
    a_r7_last_in_beat: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);

    // R7: a transfer starts only right after a host write
    a_r7_start_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> $past(bus_wr));

    // R8: the final beat is followed by an asserted interrupt
    a_r8_done_irq: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |=> irq);

    // R4: a nonzero receive count only ever steps down by one
    a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rx_cnt) != '0 && rx_cnt != $past(rx_cnt)) |-> rx_cnt == $past(rx_cnt) - CNT_W'(1));

    // R5: while receive done stays set, the count cannot grow
    a_r5_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rx_done) && rx_done) |-> rx_cnt <= $past(rx_cnt));

    // R11: the test request holds until a write of 0 to the control word
    a_r11_test_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(test_line) && !$past(bus_wr && bus_addr == OFS_CTL && bus_wdata == 32'd0)) |-> test_line);
endmodule

bind pktport pktport_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .tx_valid  (tx_valid),
    .tx_last   (tx_last),
    .irq       (irq),
    .busy      (busy),
    .rx_done   (rx_done),
    .rx_cnt    (rx_cnt),
    .test_line (test_line)
);

// File: tb/pktport_test.sv
module pktport_test;
    localparam int          CLK_NS = 10;
    localparam logic [63:0] ID_V   = 64'h5042_5354_0000_0102;
    localparam logic [31:0] ROUTE_V = 32'h0000_0002;

    // {address, expected word} after reset
    localparam logic [37:0] RESET_TBL [9] = '{
        {6'h00, ID_V[31:0]}, {6'h04, ID_V[63:32]}, {6'h08, 32'd0},
        {6'h0C, 32'd0},      {6'h10, 32'd0},       {6'h14, 32'd0},
        {6'h1C, 32'd0},      {6'h20, ROUTE_V},     {6'h18, 32'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_valid = 1'b0, rx_last = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        tx_valid, tx_last, irq;
    logic [7:0]  tx_data;

    int n_cmp = 0, n_bad = 0, tx_n = 0;
    bit finished = 1'b0;
    logic [7:0] tx_bytes [16];
    logic       tx_lasts [16];

    always #(CLK_NS/2) clk = ~clk;

    pktport #(.ID_VALUE(ID_V), .ROUTE_VALUE(ROUTE_V)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .irq(irq)
    );

    always @(negedge clk) begin
        if (tx_valid && tx_n < 16) begin
            tx_bytes[tx_n] = tx_data;
            tx_lasts[tx_n] = tx_last;
        end
        if (tx_valid) tx_n = tx_n + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic rx_byte(input logic [7:0] b, input logic l);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b; rx_last = l;
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    initial begin
        #(CLK_NS * 50000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 tx_valid", {31'd0, tx_valid}, 32'd0);

        // R1, R2: reset state table
        for (int i = 0; i < 9; i++) begin
            rd(RESET_TBL[i][37:32], v);
            chk("R1/R2 reset register", v, RESET_TBL[i][31:0]);
        end

        // R2: read-only registers ignore writes
        wr(6'h0C, 32'h1);
        rd(6'h0C, v);  chk("R2 busy write ignored", v, 32'd0);
        wr(6'h00, 32'hFFFF_FFFF);
        rd(6'h00, v);  chk("R2 id write ignored", v, ID_V[31:0]);

        // R3: five-byte packet
        for (int i = 0; i < 5; i++) rx_byte(8'hA0 + 8'(i), i == 4);
        rd(6'h14, v);  chk("R3 rx count", v, 32'd5);
        rd(6'h08, v);  chk("R3 rx done bit", v, 32'h2);
        chk("R12 irq on rx done", {31'd0, irq}, 32'd1);

        // R5: packet while locked is dropped; R4: ordered drain
        for (int i = 0; i < 3; i++) rx_byte(8'h50 + 8'(i), i == 2);
        for (int i = 0; i < 5; i++) begin
            rd(6'h10, v);  chk("R4/R5 rx byte", v, 32'hA0 + i);
            rd(6'h14, v);  chk("R4 count step", v, 32'(4 - i));
        end
        rd(6'h10, v);  chk("R4 read at zero", v, 32'd0);
        rd(6'h14, v);  chk("R4 count stays zero", v, 32'd0);

        // R5: done still set, count 0 -> still locked
        rx_byte(8'h61, 1'b0); rx_byte(8'h62, 1'b1);
        rd(6'h14, v);  chk("R5 locked by done", v, 32'd0);
        // R10: clearing bit 0 leaves bit 1
        wr(6'h08, 32'h1);
        rd(6'h08, v);  chk("R10 bit1 kept", v, 32'h2);
        // R5: lock lifted mid-packet, rest dropped
        rx_byte(8'h77, 1'b0);
        wr(6'h08, 32'h2);
        rx_byte(8'h78, 1'b0); rx_byte(8'h79, 1'b1);
        rd(6'h14, v);  chk("R5 skip to last", v, 32'd0);
        rd(6'h08, v);  chk("R10 bit1 cleared", v, 32'd0);
        chk("R12 irq low", {31'd0, irq}, 32'd0);

        // R6: busy during receive fill
        rx_byte(8'h11, 1'b0);
        rd(6'h0C, v);  chk("R6 busy in rx", v, 32'd1);
        rx_byte(8'h22, 1'b1);
        rd(6'h0C, v);  chk("R6 idle after rx", v, 32'd0);
        rd(6'h10, v);  chk("R4 lane byte 0x11", v, 32'h11);
        rd(6'h10, v);  chk("R4 lane byte 0x22", v, 32'h22);
        wr(6'h08, 32'h2);

        // R7/R13: six-byte transmit with garbage upper lanes
        tx_n = 0;
        wr(6'h1C, 32'd6);
        for (int i = 0; i < 5; i++) wr(6'h18, 32'hFFFF_FF00 | 32'(8'hC0 + 8'(i)));
        repeat (3) @(negedge clk);
        chk("R7 no beat before final byte", 32'(tx_n), 32'd0);
        wr(6'h18, 32'h1234_56C5);
        rd(6'h0C, v);  chk("R6 busy in tx", v, 32'd1);
        repeat (10) @(negedge clk);
        chk("R7 beat count", 32'(tx_n), 32'd6);
        for (int i = 0; i < 6; i++) begin
            chk("R7/R13 tx byte", {24'd0, tx_bytes[i]}, 32'hC0 + i);
            chk("R7 last marker", {31'd0, tx_lasts[i]}, {31'd0, i == 5});
        end
        rd(6'h08, v);  chk("R8 tx done bit", v, 32'h1);
        rd(6'h1C, v);  chk("R8 tx count cleared", v, 32'd0);
        chk("R12 irq on tx done", {31'd0, irq}, 32'd1);
        wr(6'h18, 32'h55);
        repeat (4) @(negedge clk);
        chk("R13 stray data ignored", 32'(tx_n), 32'd6);
        wr(6'h08, 32'h1);
        chk("R10 tx done cleared", {31'd0, irq}, 32'd0);

        // R9: clamp and zero length
        wr(6'h1C, 32'h0003_0000);
        rd(6'h1C, v);  chk("R9 clamp", v, 32'h0001_0000);
        wr(6'h1C, 32'd0);
        wr(6'h18, 32'h9);
        repeat (4) @(negedge clk);
        rd(6'h1C, v);  chk("R9 zero length", v, 32'd0);
        chk("R9 no beat", 32'(tx_n), 32'd6);

        // R7: single-byte packet
        wr(6'h1C, 32'd1);
        wr(6'h18, 32'h3C);
        repeat (4) @(negedge clk);
        chk("R7 single beat", 32'(tx_n), 32'd7);
        chk("R7 single byte", {24'd0, tx_bytes[6]}, 32'h3C);
        chk("R7 single last", {31'd0, tx_lasts[6]}, 32'd1);
        wr(6'h08, 32'h1);

        // R11: test interrupt
        wr(6'h08, 32'h8000_0000);
        chk("R11 irq raised", {31'd0, irq}, 32'd1);
        rd(6'h08, v);  chk("R11 first read", v, 32'h8000_0000);
        rd(6'h08, v);  chk("R11 second read", v, 32'd0);
        chk("R11 irq held", {31'd0, irq}, 32'd1);
        wr(6'h08, 32'd0);
        chk("R11 irq released", {31'd0, irq}, 32'd0);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule